// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a processor request port and a slower main-memory port. The processor presents plain word addresses. The controller decides on its own whether the addressed word is held locally. Hits are answered from the local data store. A read miss loads the whole containing block from memory, one word per memory handshake. The requested word is returned only once the full block is in place.

A parameter selects the write policy. Under write-through, every write goes to memory as a single word. A write hit also updates the local copy, and a write miss leaves the cache untouched. Under write-back, a write hit touches only the local copy and marks the line modified. A write miss first loads the block and then overwrites the word. A modified line that is displaced is written back in full before the new block is fetched. The processor is stalled by holding its ready signal low for as long as a memory sequence is in progress.

Top module: `cache_ctl`

## Requirements
- R1: A word address splits into offset (low OFF_W bits), index (next IDX_W bits) and tag (remaining bits). Each index selects exactly one line. Memory block addresses are formed as {tag, index, offset}.
- R2: A read hit raises cpu_ready in the same cycle as cpu_req, returns the cached word on cpu_rdata, and makes no memory access.
- R3: A read miss issues 2^OFF_W memory reads to {tag, index, 0} up to {tag, index, 2^OFF_W-1} in ascending order. cpu_ready stays low throughout the fill. The word is returned only after the last fill word, at which point the line is valid.
- R4: Under write-through (WRITE_BACK=0), a write hit makes exactly one memory write with the request's address and data. It also updates the cached word, so a later read hit returns the new value without a memory access.
- R5: Under write-through, a write miss makes exactly one memory write and does not allocate a line. A later read of that block misses and fills.
- R6: Under write-back (WRITE_BACK=1), a write hit makes no memory access, raises cpu_ready in the request cycle, and marks the line dirty.
- R7: Under write-back, a write miss first fills the block and then overwrites the addressed word. A later read returns the written value without a memory access.
- R8: Under write-back, a miss on a dirty line first writes all 2^OFF_W words of the old block to {old tag, index, offset} in ascending offset order. Only after that do the fill reads begin.
- R9: Under write-back, a miss on a valid clean line makes no writeback and goes straight to the fill.
- R10: After reset all lines are invalid, cpu_ready and mem_req are low, and the first access to any address misses.
- R11: mem_req, mem_addr and mem_we stay unchanged from the cycle a memory access is raised until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | Request completes in this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access done this cycle |

## Verification
Under write-back, a write miss to a dirty line chains three actions on one index: the eviction writeback, the fill, and the word overwrite. The last writeback acknowledge and the first fill request also meet on consecutive cycles. Under write-through, the memory acknowledge and the local word update of a write hit fall in the same cycle. Both cases are provoked by sweeping all addresses with reads, then writes, then a scrambled read pass, so every line is evicted both dirty and clean. They are judged against a bench model of tags, dirty flags and values that predicts the exact memory access list (order, address, direction, data) and the returned data.

// File: rtl/cache_ctl.sv
module cache_ctl #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 2,
  parameter int OFF_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL, S_WTHRU} st_t;

  st_t                      st_q;
  logic [TAG_W-1:0]         tag_q [LINES];
  logic [DATA_W-1:0]        dat_q [LINES*WORDS];
  logic [LINES-1:0]         vld_q, dty_q;
  logic [OFF_W-1:0]         cnt_q;

  wire [TAG_W-1:0] a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] a_idx = cpu_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] a_off = cpu_addr[OFF_W-1:0];
  wire             hit   = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  wire             last  = &cnt_q;

  assign cpu_rdata = dat_q[{a_idx, a_off}];
  assign cpu_ready = (st_q == S_IDLE) ? (cpu_req && hit && (WRITE_BACK || !cpu_we))
                                      : (st_q == S_WTHRU && mem_ack);
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WBACK) || (st_q == S_WTHRU);

  always_comb begin
    case (st_q)
      S_WBACK: mem_addr = {tag_q[a_idx], a_idx, cnt_q};
      S_FILL:  mem_addr = {a_tag, a_idx, cnt_q};
      default: mem_addr = cpu_addr;
    endcase
  end

  assign mem_wdata = (st_q == S_WBACK) ? dat_q[{a_idx, cnt_q}] : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      vld_q <= '0;
      dty_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cpu_req) begin
          if (cpu_we && !WRITE_BACK) begin
            st_q <= S_WTHRU;
          end else if (hit) begin
            if (cpu_we) dty_q[a_idx] <= 1'b1;
          end else begin
            cnt_q <= '0;
            if (WRITE_BACK && vld_q[a_idx] && dty_q[a_idx]) begin
              st_q <= S_WBACK;
            end else begin
              st_q         <= S_FILL;
              vld_q[a_idx] <= 1'b0;
            end
          end
        end
        S_WBACK: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            st_q         <= S_FILL;
            dty_q[a_idx] <= 1'b0;
            vld_q[a_idx] <= 1'b0;
          end
        end
        S_FILL: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            st_q         <= S_IDLE;
            vld_q[a_idx] <= 1'b1;
            dty_q[a_idx] <= 1'b0;
          end
        end
        default: if (mem_ack) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    case (st_q)
      S_IDLE:  if (cpu_req && cpu_we && WRITE_BACK && hit) dat_q[{a_idx, a_off}] <= cpu_wdata;
      S_FILL:  if (mem_ack) begin
        dat_q[{a_idx, cnt_q}] <= mem_rdata;
        if (last) tag_q[a_idx] <= a_tag;
      end
      S_WTHRU: if (mem_ack && hit) dat_q[{a_idx, a_off}] <= cpu_wdata;
      default: ;
    endcase
  end

  p_stall_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WBACK || st_q == S_FILL) |-> !cpu_ready);

  p_fill_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL) |-> !vld_q[a_idx]);

  p_valid_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL && mem_ack && last) |=> vld_q[$past(a_idx)]);

  p_read_hit_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> !mem_req);

  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WBACK && mem_ack && last) |=> (mem_req && !mem_we && st_q == S_FILL));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  generate
    if (!WRITE_BACK) begin : g_wt_chk
      p_never_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dty_q == '0);
    end
  endgenerate
endmodule

// File: tb/cache_ctl_tb.sv
module cache_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  req = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;

  int ncomp = 0, nfail = 0, cyc_all = 0;

  logic [15:0] sh [2][256];
  bit          vv [2][4];
  bit          vd [2][4];
  int          vt [2][4];

  for (genvar g = 0; g < 2; g++) begin : g_pol
    logic        rdy_w, mreq, mwe, mack;
    logic [15:0] rd_w, mwd, mrd;
    logic [7:0]  maddr, hold_a;
    logic [15:0] mem_q [256];
    int lg_a [1024];
    int lg_w [1024];
    int lg_d [1024];
    int lgn = 0, r11c = 0, r11f = 0;

    cache_ctl #(.WRITE_BACK(g != 0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(req[g]), .cpu_we(we), .cpu_addr(addr),
      .cpu_wdata(wdata), .cpu_rdata(rd_w), .cpu_ready(rdy_w), .mem_req(mreq),
      .mem_we(mwe), .mem_addr(maddr), .mem_wdata(mwd), .mem_rdata(mrd), .mem_ack(mack));

    always @(posedge clk) begin
      if (!rst_n) begin
        mack <= 1'b0;
        mrd  <= '0;
        hold_a <= '0;
        for (int a = 0; a < 256; a++) mem_q[a] <= 16'h1000 + 16'(a * 3);
      end else begin
        if (mack) begin
          r11c <= r11c + 1;
          if (maddr !== hold_a) begin
            r11f <= r11f + 1;
            $display("FAIL R11 address held until ack: actual %0h expected %0h", maddr, hold_a);
          end
        end
        mack <= mreq & !mack;
        if (mreq && !mack) begin
          hold_a <= maddr;
          lg_a[lgn % 1024] <= int'(maddr);
          lg_w[lgn % 1024] <= int'(mwe);
          lg_d[lgn % 1024] <= int'(mwd);
          lgn <= lgn + 1;
          if (mwe) mem_q[maddr] <= mwd;
          else     mrd <= mem_q[maddr];
        end
      end
    end
  end

  function automatic bit rdy_of(int p);
    return p != 0 ? g_pol[1].rdy_w : g_pol[0].rdy_w;
  endfunction
  function automatic logic [15:0] rd_of(int p);
    return p != 0 ? g_pol[1].rd_w : g_pol[0].rd_w;
  endfunction
  function automatic int lgn_of(int p);
    return p != 0 ? g_pol[1].lgn : g_pol[0].lgn;
  endfunction
  function automatic int lga_of(int p, int k);
    return p != 0 ? g_pol[1].lg_a[k % 1024] : g_pol[0].lg_a[k % 1024];
  endfunction
  function automatic int lgw_of(int p, int k);
    return p != 0 ? g_pol[1].lg_w[k % 1024] : g_pol[0].lg_w[k % 1024];
  endfunction
  function automatic int lgd_of(int p, int k);
    return p != 0 ? g_pol[1].lg_d[k % 1024] : g_pol[0].lg_d[k % 1024];
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    ncomp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    int c, f;
    c = ncomp + g_pol[0].r11c + g_pol[1].r11c;
    f = nfail + g_pol[0].r11f + g_pol[1].r11f;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", c, f);
  endtask

  task automatic op(input int p, input bit w, input int a, input logic [15:0] d);
    int tg, ix, n0, cyc, en, line;
    int ea [8];
    int ew [8];
    int ed [8];
    bit hit, evd, wt;
    string cat;
    logic [15:0] got;
    tg  = a >> 4;
    ix  = (a >> 2) & 3;
    hit = vv[p][ix] && vt[p][ix] == tg;
    wt  = (p == 0) && w;
    evd = (p == 1) && !hit && vv[p][ix] && vd[p][ix];
    en  = 0;
    if (wt) begin
      ea[0] = a; ew[0] = 1; ed[0] = int'(d); en = 1;
      cat = hit ? "R4" : "R5";
    end else begin
      if (w) cat = hit ? "R6" : "R7";
      else   cat = hit ? "R2" : "R3";
      if (!hit) begin
        if (evd) begin
          cat = {cat, "/R8"};
          for (int k = 0; k < 4; k++) begin
            line = (vt[p][ix] << 4) | (ix << 2) | k;
            ea[en] = line; ew[en] = 1; ed[en] = int'(sh[p][line]); en++;
          end
        end else if (p == 1 && vv[p][ix]) begin
          cat = {cat, "/R9"};
        end
        for (int k = 0; k < 4; k++) begin
          ea[en] = (tg << 4) | (ix << 2) | k; ew[en] = 0; ed[en] = 0; en++;
        end
      end
    end
    n0 = lgn_of(p);
    @(negedge clk);
    addr = 8'(a); we = w; wdata = d; req[p] = 1'b1; cyc = 0;
    #1;
    while (!rdy_of(p) && cyc <= 500) begin
      @(negedge clk); #1; cyc++;
    end
    got = rd_of(p);
    @(negedge clk);
    req[p] = 1'b0;
    if (cyc > 500) begin
      chk(1'b0, cat, "watchdog on request", cyc, 500);
      return;
    end
    if (!w) chk(got == sh[p][a], cat, "read data", int'(got), int'(sh[p][a]));
    chk(lgn_of(p) - n0 == en, cat, "memory access count", lgn_of(p) - n0, en);
    for (int k = 0; k < en && k < lgn_of(p) - n0; k++) begin
      chk(lga_of(p, n0 + k) == ea[k], {cat, "/R1"}, "memory address", lga_of(p, n0 + k), ea[k]);
      chk(lgw_of(p, n0 + k) == ew[k], cat, "memory direction", lgw_of(p, n0 + k), ew[k]);
      if (ew[k] != 0) chk(lgd_of(p, n0 + k) == ed[k], cat, "memory write data", lgd_of(p, n0 + k), ed[k]);
    end
    if (hit && !wt) chk(cyc == 0, cat, "hit latency", cyc, 0);
    if (!hit && !wt) chk(cyc >= 8, cat, "word held until block loaded", cyc, 8);
    if (wt) begin
      sh[p][a] = d;
    end else begin
      if (!hit) begin vv[p][ix] = 1; vt[p][ix] = tg; vd[p][ix] = 0; end
      if (w) begin sh[p][a] = d; vd[p][ix] = 1; end
    end
  endtask

  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all == 190000) begin
      ncomp++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_all);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] v;
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++) sh[p][a] = 16'h1000 + 16'(a * 3);
      for (int i = 0; i < 4; i++) begin vv[p][i] = 0; vd[p][i] = 0; vt[p][i] = 0; end
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(rdy_of(p) == 1'b0, "R10", "ready in reset", int'(rdy_of(p)), 0);
    end
    chk(g_pol[0].mreq == 1'b0 && g_pol[1].mreq == 1'b0, "R10", "mem_req in reset",
        int'({g_pol[1].mreq, g_pol[0].mreq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(g_pol[0].mreq == 1'b0 && g_pol[1].mreq == 1'b0, "R10", "mem_req idle after reset",
        int'({g_pol[1].mreq, g_pol[0].mreq}), 0);
    chk(rdy_of(0) == 1'b0 && rdy_of(1) == 1'b0, "R10", "ready idle after reset",
        int'({rdy_of(1), rdy_of(0)}), 0);
    for (int p = 0; p < 2; p++) begin
      n = lgn_of(p);
      op(p, 1'b0, 0, 16'h0);
      chk(lgn_of(p) - n == 4, "R10", "first access misses", lgn_of(p) - n, 4);
      for (int a = 0; a < 256; a++) op(p, 1'b0, a, 16'h0);
      for (int a = 0; a < 256; a++) begin
        v = 16'(a * 13) ^ 16'hA5A0 ^ 16'(p);
        op(p, 1'b1, a, v);
      end
      for (int i = 0; i < 256; i++) op(p, 1'b0, (i * 37) & 255, 16'h0);
      for (int i = 0; i < 64; i++) begin
        v = ~(16'(i * 91) ^ 16'h3C00);
        op(p, 1'b1, (i * 91 + 5) & 255, v);
        op(p, 1'b0, (i * 91 + 5) & 255, 16'h0);
        op(p, 1'b0, (i * 91 + 5) & 255, 16'h0);
      end
    end
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule